// File: doc/BRIEF.md
# Exception entry and status save unit

This unit sits beside a processor's control path and decides, each clock, whether an exception is taken. It looks at seven request lines, drops IRQ and FIQ requests that the current status word masks, and picks the most urgent of the rest. One clock later it issues a redirect strobe with the fixed vector address of that exception. In the same clock it gives the status word the core must adopt: the handler's mode, the interrupt-disable bits set and the instruction-set bit cleared. The status word that was current is written into the saved-status bank of the mode being entered.

A return strobe takes the opposite path. When the current mode has a saved-status bank, the unit gives back the copy stored in that bank as the new status word. User mode, system mode and any unknown mode encoding have no bank. For those the return leaves the status word as it is and pulses an error flag. When no exception and no return take effect, the output status word is the input status word delayed by one clock. The five banks are brought out as ports so they can be inspected.

Top module: `exc_entry_unit`

## Requirements
- R1: While rst_n is low, sr_out is 0x000000D3 (supervisor mode with both interrupt-disable bits set), vec_pc equals VEC_BASE, redirect and ret_err are 0 and all five banks are zero.
- R2: A request taken in cycle n gives redirect = 1 for exactly one cycle in cycle n+1. vec_pc then holds VEC_BASE plus the vector offset and keeps that value until the next exception is taken. The offsets are reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18 and FIQ 0x1C. Offset 0x14 is never produced.
- R3: When several effective requests are present, exactly one is taken. The order from highest to lowest is reset, data abort, FIQ, IRQ, prefetch abort, undefined instruction, software interrupt.
- R4: An IRQ request is ignored while sr_in bit 7 is 1. An FIQ request is ignored while sr_in bit 6 is 1.
- R5: On entry, sr_out bits [4:0] become the handler mode. The mode codes are user 0x10, FIQ 0x11, IRQ 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F. Reset and software interrupt enter supervisor mode, both aborts enter abort mode, and the other requests enter the mode of the same name. Bit 7 is set and bit 5 (instruction-set state) is cleared. Bit 6 is set on reset and FIQ entry and is otherwise kept. All other bits (flags [31:28], endianness bit 9, the rest) are copied from sr_in.
- R6: On entry, the bank of the target mode receives the sr_in value of the request cycle. The other banks keep their values.
- R7: A return when sr_in bits [4:0] name FIQ, IRQ, supervisor, abort or undefined mode sets sr_out to that mode's bank one cycle later. No bank changes.
- R8: A return in any other mode (user, system or an unknown code) sets sr_out to sr_in, pulses ret_err for one cycle and changes no bank.
- R9: When an exception is taken in the same cycle as a return, the exception is handled and the return has no effect: no ret_err, and no restored status.
- R10: In a cycle with no taken exception and no return, sr_out takes the sr_in value one cycle later and redirect stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the unit |
| rst_req | input | 1 | Reset exception request |
| dabt_req | input | 1 | Data abort request |
| fiq_req | input | 1 | Fast interrupt request |
| irq_req | input | 1 | Normal interrupt request |
| pabt_req | input | 1 | Prefetch abort request |
| und_req | input | 1 | Undefined instruction request |
| swi_req | input | 1 | Software interrupt request |
| ret | input | 1 | Exception return strobe |
| sr_in | input | 32 | Current status word |
| vec_pc | output | PC_W | Vector address of the last taken exception |
| redirect | output | 1 | One-cycle strobe marking a new vector |
| sr_out | output | 32 | Updated status word |
| ret_err | output | 1 | One-cycle flag for a return without a saved copy |
| bank_fiq | output | 32 | Saved status of FIQ mode |
| bank_irq | output | 32 | Saved status of IRQ mode |
| bank_svc | output | 32 | Saved status of supervisor mode |
| bank_abt | output | 32 | Saved status of abort mode |
| bank_und | output | 32 | Saved status of undefined mode |

## Verification
The bench builds the unit with PC_W = 32 and VEC_BASE = 0xFFFF0000. The non-zero high base makes any loss of base bits or any error in adding the offset visible on vec_pc. The reference model drives the status-word input with handler modes, user, system and an unknown mode code, which covers both the restore path and the error path of a return. Random request mixes over both mask bits test every priority pair against the masking rule.

// File: rtl/exc_entry_unit.sv
module exc_entry_unit #(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] VEC_BASE = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_req,
  input  logic            dabt_req,
  input  logic            fiq_req,
  input  logic            irq_req,
  input  logic            pabt_req,
  input  logic            und_req,
  input  logic            swi_req,
  input  logic            ret,
  input  logic [31:0]     sr_in,
  output logic [PC_W-1:0] vec_pc,
  output logic            redirect,
  output logic [31:0]     sr_out,
  output logic            ret_err,
  output logic [31:0]     bank_fiq,
  output logic [31:0]     bank_irq,
  output logic [31:0]     bank_svc,
  output logic [31:0]     bank_abt,
  output logic [31:0]     bank_und
);
  localparam int NB = 5;
  localparam logic [4:0] M_FIQ = 5'h11, M_IRQ = 5'h12, M_SVC = 5'h13,
                         M_ABT = 5'h17, M_UND = 5'h1B;
  localparam logic [31:0] SR_RST = 32'h0000_00D3;

  logic [31:0] bank [NB];
  logic        take, set_f, ret_ok;
  logic [2:0]  slot, tidx, ridx;
  logic [4:0]  tmode;

  wire irq_ok = irq_req & ~sr_in[7];
  wire fiq_ok = fiq_req & ~sr_in[6];

  always_comb begin
    take = 1'b1; set_f = 1'b0; slot = 3'd0; tmode = M_SVC;
    if (rst_req)       begin slot = 3'd0; tmode = M_SVC; set_f = 1'b1; end
    else if (dabt_req) begin slot = 3'd4; tmode = M_ABT; end
    else if (fiq_ok)   begin slot = 3'd7; tmode = M_FIQ; set_f = 1'b1; end
    else if (irq_ok)   begin slot = 3'd6; tmode = M_IRQ; end
    else if (pabt_req) begin slot = 3'd3; tmode = M_ABT; end
    else if (und_req)  begin slot = 3'd1; tmode = M_UND; end
    else if (swi_req)  begin slot = 3'd2; tmode = M_SVC; end
    else take = 1'b0;
  end

  always_comb begin
    case (tmode)
      M_FIQ:   tidx = 3'd0;
      M_IRQ:   tidx = 3'd1;
      M_ABT:   tidx = 3'd3;
      M_UND:   tidx = 3'd4;
      default: tidx = 3'd2;
    endcase
  end

  always_comb begin
    ret_ok = 1'b1;
    case (sr_in[4:0])
      M_FIQ:   ridx = 3'd0;
      M_IRQ:   ridx = 3'd1;
      M_SVC:   ridx = 3'd2;
      M_ABT:   ridx = 3'd3;
      M_UND:   ridx = 3'd4;
      default: begin ridx = 3'd0; ret_ok = 1'b0; end
    endcase
  end

  wire [31:0] entry_sr = {sr_in[31:8], 1'b1, sr_in[6] | set_f, 1'b0, tmode};
  wire        do_ret   = ret & ~take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_pc   <= VEC_BASE;
      redirect <= 1'b0;
      sr_out   <= SR_RST;
      ret_err  <= 1'b0;
      for (int i = 0; i < NB; i++) bank[i] <= '0;
    end else begin
      redirect <= take;
      ret_err  <= do_ret & ~ret_ok;
      if (take) vec_pc <= VEC_BASE + PC_W'({slot, 2'b00});
      if (take)                 sr_out <= entry_sr;
      else if (do_ret && ret_ok) sr_out <= bank[ridx];
      else                      sr_out <= sr_in;
      for (int i = 0; i < NB; i++)
        if (take && tidx == 3'(i)) bank[i] <= sr_in;
    end
  end

  assign bank_fiq = bank[0];
  assign bank_irq = bank[1];
  assign bank_svc = bank[2];
  assign bank_abt = bank[3];
  assign bank_und = bank[4];
endmodule

// File: rtl/exc_entry_unit_chk.sv
module exc_entry_unit_chk #(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] VEC_BASE = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rst_req,
  input logic            dabt_req,
  input logic            fiq_req,
  input logic            irq_req,
  input logic            pabt_req,
  input logic            und_req,
  input logic            swi_req,
  input logic            ret,
  input logic [31:0]     sr_in,
  input logic [PC_W-1:0] vec_pc,
  input logic            redirect,
  input logic [31:0]     sr_out,
  input logic            ret_err,
  input logic [31:0]     bank_fiq,
  input logic [31:0]     bank_irq,
  input logic [31:0]     bank_svc,
  input logic [31:0]     bank_abt,
  input logic [31:0]     bank_und
);
  wire others_off = !rst_req && !dabt_req && !fiq_req && !pabt_req && !und_req && !swi_req;

  a_r3_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (redirect && vec_pc == VEC_BASE && sr_out[4:0] == 5'h13));

  a_r3_dabt_over_fiq: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_req && dabt_req) |=> (vec_pc == VEC_BASE + PC_W'(16)));

  a_r4_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && sr_in[7] && others_off) |=> !redirect);

  a_r5_entry_masks: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (sr_out[7] && !sr_out[5]));

  a_r2_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (vec_pc != VEC_BASE + PC_W'(20)));

  a_r6_banks_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |-> ($stable(bank_fiq) && $stable(bank_irq) && $stable(bank_svc)
                   && $stable(bank_abt) && $stable(bank_und)));

  a_r8_err_keeps_sr: assert property (@(posedge clk) disable iff (!rst_n)
    ret_err |-> (sr_out == $past(sr_in) && !redirect));

  a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({redirect, ret_err}));
endmodule

bind exc_entry_unit exc_entry_unit_chk #(.PC_W(PC_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .dabt_req(dabt_req),
  .fiq_req(fiq_req), .irq_req(irq_req), .pabt_req(pabt_req),
  .und_req(und_req), .swi_req(swi_req), .ret(ret), .sr_in(sr_in),
  .vec_pc(vec_pc), .redirect(redirect), .sr_out(sr_out), .ret_err(ret_err),
  .bank_fiq(bank_fiq), .bank_irq(bank_irq), .bank_svc(bank_svc),
  .bank_abt(bank_abt), .bank_und(bank_und));

// File: tb/exc_entry_unit_bench.sv
module exc_entry_unit_bench;
  localparam logic [31:0] BASE = 32'hFFFF_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rst_req = 0, dabt_req = 0, fiq_req = 0, irq_req = 0;
  logic pabt_req = 0, und_req = 0, swi_req = 0, ret = 0;
  logic [31:0] sr_in = '0;
  logic [31:0] vec_pc, sr_out, bank_fiq, bank_irq, bank_svc, bank_abt, bank_und;
  logic redirect, ret_err;

  int checks = 0, errors = 0;
  logic [31:0] e_sr, e_vec;
  logic        e_red, e_err;
  logic [31:0] e_bank [5];

  always #4 clk = ~clk;

  exc_entry_unit #(.PC_W(32), .VEC_BASE(BASE)) u_exc_entry_unit (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .dabt_req(dabt_req),
    .fiq_req(fiq_req), .irq_req(irq_req), .pabt_req(pabt_req),
    .und_req(und_req), .swi_req(swi_req), .ret(ret), .sr_in(sr_in),
    .vec_pc(vec_pc), .redirect(redirect), .sr_out(sr_out), .ret_err(ret_err),
    .bank_fiq(bank_fiq), .bank_irq(bank_irq), .bank_svc(bank_svc),
    .bank_abt(bank_abt), .bank_und(bank_und));

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int bank_of(input logic [4:0] m);
    case (m)
      5'h11: return 0;
      5'h12: return 1;
      5'h13: return 2;
      5'h17: return 3;
      5'h1B: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic model();
    int off = -1;
    logic [4:0] m = 5'h13;
    logic f = 0;
    int b;
    if (rst_req) begin off = 0; m = 5'h13; f = 1; end
    else if (dabt_req) begin off = 16; m = 5'h17; end
    else if (fiq_req && !sr_in[6]) begin off = 28; m = 5'h11; f = 1; end
    else if (irq_req && !sr_in[7]) begin off = 24; m = 5'h12; end
    else if (pabt_req) begin off = 12; m = 5'h17; end
    else if (und_req) begin off = 4; m = 5'h1B; end
    else if (swi_req) begin off = 8; m = 5'h13; end
    e_red = (off >= 0);
    e_err = 0;
    if (off >= 0) begin
      e_vec = BASE + off;
      e_bank[bank_of(m)] = sr_in;
      e_sr = sr_in;
      e_sr[4:0] = m; e_sr[5] = 0; e_sr[7] = 1;
      if (f) e_sr[6] = 1;
    end else if (ret) begin
      b = bank_of(sr_in[4:0]);
      if (b >= 0) e_sr = e_bank[b];
      else begin e_sr = sr_in; e_err = 1; end
    end else e_sr = sr_in;
  endtask

  task automatic compare(input string tag);
    chk(tag, "redirect", 32'(redirect), 32'(e_red));
    chk(tag, "vec_pc", vec_pc, e_vec);
    chk(tag, "sr_out", sr_out, e_sr);
    chk(tag, "ret_err", 32'(ret_err), 32'(e_err));
    chk(tag, "bank_fiq", bank_fiq, e_bank[0]);
    chk(tag, "bank_irq", bank_irq, e_bank[1]);
    chk(tag, "bank_svc", bank_svc, e_bank[2]);
    chk(tag, "bank_abt", bank_abt, e_bank[3]);
    chk(tag, "bank_und", bank_und, e_bank[4]);
  endtask

  // rq order: {rst, dabt, fiq, irq, pabt, und, swi}
  task automatic step(input string tag, input logic [6:0] rq, input logic [31:0] sr, input logic r);
    {rst_req, dabt_req, fiq_req, irq_req, pabt_req, und_req, swi_req} = rq;
    sr_in = sr; ret = r;
    @(posedge clk);
    model();
    @(negedge clk);
    compare(tag);
  endtask

  localparam logic [4:0] MODES [8] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h00};

  initial begin
    logic [31:0] s;
    e_sr = 32'h0000_00D3; e_vec = BASE; e_red = 0; e_err = 0;
    for (int i = 0; i < 5; i++) e_bank[i] = '0;
    repeat (2) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;

    step("R10", 7'b0, 32'h9000_0210, 0);
    step("R10", 7'b0, 32'h1234_56D0, 0);

    for (int k = 0; k < 7; k++) begin
      step("R2", 7'(1 << k), 32'hA000_0230, 0);
      step("R5", 7'b0, 32'h5000_0210, 0);
    end
    step("R6", 7'b0001000, 32'h3000_0110, 0);

    step("R3", 7'b1111111, 32'h0000_0010, 0);
    step("R3", 7'b0111111, 32'h0000_0010, 0);
    step("R3", 7'b0011111, 32'h0000_0010, 0);
    step("R3", 7'b0001111, 32'h0000_0010, 0);
    step("R3", 7'b0000111, 32'h0000_0010, 0);
    step("R3", 7'b0000011, 32'h0000_0010, 0);

    step("R4", 7'b0001000, 32'h0000_0090, 0);
    step("R4", 7'b0010000, 32'h0000_0050, 0);
    step("R4", 7'b0011001, 32'h0000_00D0, 0);
    step("R4", 7'b0001000, 32'h0000_0050, 0);

    foreach (MODES[j]) begin
      s = 32'hC000_0200 | 32'(MODES[j]);
      step(bank_of(MODES[j]) >= 0 ? "R7" : "R8", 7'b0, s, 1);
    end
    step("R8", 7'b0, 32'h0000_001F, 1);
    step("R9", 7'b0000010, 32'h0000_0012, 1);
    step("R9", 7'b0000100, 32'h0000_0010, 1);

    for (int n = 0; n < 600; n++) begin
      logic [6:0] rq;
      rq = 7'($urandom) & 7'($urandom) & 7'($urandom);
      s = $urandom;
      s[4:0] = MODES[$urandom % 8];
      step("R3", rq, s, 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule